// File: doc/BRIEF.md
# UART interrupt and wake-up controller

This block gathers the event flags of a serial port into two 8-bit status registers and merges them into one active-high interrupt line. Transmitter and receiver logic report events as single-cycle pulses. Each pulse sets a sticky flag, and software clears a flag by writing one to its bit. Every flag passes through its own local enable before the combined OR. That OR is registered, so the interrupt line never glitches.

The block also watches the raw receive pin for an active edge. The active edge is falling or rising, chosen by a polarity input. The capture stage is clocked by the pin itself, so it keeps working while the bus clock is stopped for low-power stop mode. A captured edge raises a wake request during stop. The capture then enters the bus-clock domain through a synchronizer and sets the edge flag.

In wait mode with freezing enabled, the block tells the datapath to hold and ignores its events. Stop mode models a gated bus clock: all bus-side state holds. A reset clears everything.

Top module: `uart_evt_irq_ctrl`

## Requirements
- R1: After reset, both status registers read 0x00, and `irq_o`, `wake_o` and `halt_o` are 0.
- R2: A one-cycle event pulse sets its flag at the next clock edge. Main register bit positions: 7 transmit-empty, 6 transmit-complete, 5 receive-full, 4 idle, 3 overrun. Aux register bit positions: 7 receive edge, 1 bit error, 0 break. The remaining bits always read 0.
- R3: Writing one to a status bit through `clr_main_i` or `clr_aux_i` clears that flag at the next edge. Writing zero has no effect, and writes to unused bits have no effect.
- R4: When a set event and a clear of the same flag arrive in the same cycle, the flag is left set.
- R5: `irq_o` is the registered OR of all enabled flags. It rises one cycle after an enabled flag is set and falls one cycle after the last enabled flag clears. A flag whose enable is 0 never drives it. Bit positions of `irq_en_i`: 0 transmit-empty, 1 transmit-complete, 2 receive (full and overrun), 3 idle, 4 edge, 5 bit error, 6 break.
- R6: The receive-full and overrun flags share one enable, `irq_en_i[2]`.
- R7: With `edge_pol_i`=0 a falling edge on `rx_pin_i` sets the edge flag, and a rising edge does not. With `edge_pol_i`=1 a rising edge sets it, and a falling edge does not. The flag appears within SYNC_STAGES+2 bus clocks of the edge.
- R8: The bit-error flag sets only when `one_wire_i` and `bit_chk_i` are both high and `tx_bit_i` differs from `line_bit_i`.
- R9: While `wait_i` and `wait_halt_en_i` are both high, `halt_o` is 1 and transmitter and receiver event pulses are ignored. With `wait_halt_en_i` low, wait mode changes nothing.
- R10: While `stop_i` is high, the status registers, their clears and `irq_o` all hold. An active receive edge raises `wake_o` with no bus clock involved. After stop ends, the edge flag sets and `wake_o` falls.
- R11: Asserting reset during stop clears all flags, `irq_o` and any pending wake request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_empty_evt_i | input | 1 | Pulse: transmit data register emptied |
| tx_done_evt_i | input | 1 | Pulse: transmission complete |
| rx_full_evt_i | input | 1 | Pulse: received data available |
| rx_idle_evt_i | input | 1 | Pulse: receive line went idle |
| rx_overrun_evt_i | input | 1 | Pulse: receive overrun |
| rx_break_evt_i | input | 1 | Pulse: break character received |
| one_wire_i | input | 1 | Single-wire operation active |
| bit_chk_i | input | 1 | Strobe: compare transmitted and read-back bit |
| tx_bit_i | input | 1 | Bit being transmitted |
| line_bit_i | input | 1 | Bit read back from the line |
| rx_pin_i | input | 1 | Raw receive pin, asynchronous |
| edge_pol_i | input | 1 | Active edge select: 0 falling, 1 rising |
| irq_en_i | input | 7 | Local interrupt enables |
| clr_main_i | input | 8 | Write-one-to-clear strobe, main register |
| clr_aux_i | input | 8 | Write-one-to-clear strobe, aux register |
| wait_i | input | 1 | Wait mode active |
| wait_halt_en_i | input | 1 | Freeze activity in wait mode |
| stop_i | input | 1 | Stop mode, bus clock gated |
| stat_main_o | output | 8 | Main status register |
| stat_aux_o | output | 8 | Aux status register |
| irq_o | output | 1 | Combined interrupt, active high |
| wake_o | output | 1 | Wake request from receive edge during stop |
| halt_o | output | 1 | Freeze request to the datapath |

## Verification
Each flag is a single sticky bit read straight out on a status port. A wrong set, clear or priority decision therefore shows one clock after the offending event, and the interrupt line shows it one clock after that. A mismatch between the enables and the flags shows as `irq_o` wrongly high or low two cycles after the stimulus. A fault in the edge capture or its handshake shows as a missing or duplicate edge flag a few bus clocks after the pin moves. It can also show as `wake_o` staying high after stop ends.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int unsigned SRC_N  = 8;
   localparam int unsigned STAT_W = 8;
   localparam int unsigned EN_W   = 7;

   // internal flag indices
   localparam int unsigned IX_TXE = 0;
   localparam int unsigned IX_TXC = 1;
   localparam int unsigned IX_RXF = 2;
   localparam int unsigned IX_IDL = 3;
   localparam int unsigned IX_OVR = 4;
   localparam int unsigned IX_EDG = 5;
   localparam int unsigned IX_BER = 6;
   localparam int unsigned IX_BRK = 7;

   // enable bit positions
   localparam int unsigned EN_TXE = 0;
   localparam int unsigned EN_TXC = 1;
   localparam int unsigned EN_RX  = 2;
   localparam int unsigned EN_IDL = 3;
   localparam int unsigned EN_EDG = 4;
   localparam int unsigned EN_BER = 5;
   localparam int unsigned EN_BRK = 6;

   // status register bit positions
   localparam int unsigned MB_TXE = 7;
   localparam int unsigned MB_TXC = 6;
   localparam int unsigned MB_RXF = 5;
   localparam int unsigned MB_IDL = 4;
   localparam int unsigned MB_OVR = 3;
   localparam int unsigned AB_EDG = 7;
   localparam int unsigned AB_BER = 1;
   localparam int unsigned AB_BRK = 0;
endpackage

// File: rtl/uart_flag_bank.sv
module uart_flag_bank #(
   parameter int unsigned N = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         run_i,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);
   if (N < 1) begin : g_bad_n
      $error("uart_flag_bank: N must be at least 1");
   end

   for (genvar g = 0; g < N; g++) begin : g_flag
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)    q <= 1'b0;
         else if (run_i) q <= set_i[g] | (q & ~clr_i[g]);
      end
      assign flag_o[g] = q;

      a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (run_i && set_i[g]) |=> flag_o[g]);
      a_r3_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (run_i && clr_i[g] && !set_i[g]) |=> !flag_o[g]);
   end

   a_r10_hold_in_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> $stable(flag_o));
endmodule

// File: rtl/uart_irq_merge.sv
module uart_irq_merge #(
   parameter int unsigned N = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         run_i,
   input  logic [N-1:0] flag_i,
   input  logic [N-1:0] mask_i,
   output logic         irq_o
);
   logic hit;
   logic irq_q;

   assign hit = |(flag_i & mask_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    irq_q <= 1'b0;
      else if (run_i) irq_q <= hit;
   end
   assign irq_o = irq_q;

   a_r5_rise_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && hit) |=> irq_o);
   a_r5_fall_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && !hit) |=> !irq_o);
endmodule

// File: rtl/uart_rx_edge_wake.sv
module uart_rx_edge_wake #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic rx_pin_i,
   input  logic pol_i,
   output logic edge_pulse_o,
   output logic pending_o
);
   logic trig;
   logic cap_q;
   logic cap_clr;
   logic ack_q;
   logic [SYNC_STAGES-1:0] sync_q;

   // rising trig == active edge of the pin for the chosen polarity
   assign trig    = ~(rx_pin_i ^ pol_i);
   assign cap_clr = ack_q | ~rst_ni;

   always_ff @(posedge trig or posedge cap_clr) begin
      if (cap_clr) cap_q <= 1'b0;
      else         cap_q <= 1'b1;
   end

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      logic d;
      logic q;
      if (s == 0) begin : g_head
         assign d = cap_q;
      end else begin : g_tail
         assign d = sync_q[s-1];
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)    q <= 1'b0;
         else if (run_i) q <= d;
      end
      assign sync_q[s] = q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    ack_q <= 1'b0;
      else if (run_i) ack_q <= sync_q[SYNC_STAGES-1];
   end

   assign edge_pulse_o = sync_q[SYNC_STAGES-1] & ~ack_q;
   assign pending_o    = cap_q;

   a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && edge_pulse_o) |=> !edge_pulse_o);
endmodule

// File: rtl/uart_evt_irq_ctrl.sv
module uart_evt_irq_ctrl
   import uart_irq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tx_empty_evt_i,
   input  logic              tx_done_evt_i,
   input  logic              rx_full_evt_i,
   input  logic              rx_idle_evt_i,
   input  logic              rx_overrun_evt_i,
   input  logic              rx_break_evt_i,
   input  logic              one_wire_i,
   input  logic              bit_chk_i,
   input  logic              tx_bit_i,
   input  logic              line_bit_i,
   input  logic              rx_pin_i,
   input  logic              edge_pol_i,
   input  logic [EN_W-1:0]   irq_en_i,
   input  logic [STAT_W-1:0] clr_main_i,
   input  logic [STAT_W-1:0] clr_aux_i,
   input  logic              wait_i,
   input  logic              wait_halt_en_i,
   input  logic              stop_i,
   output logic [STAT_W-1:0] stat_main_o,
   output logic [STAT_W-1:0] stat_aux_o,
   output logic              irq_o,
   output logic              wake_o,
   output logic              halt_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("uart_evt_irq_ctrl: SYNC_STAGES must be at least 2");
   end
   if (STAT_W < 8) begin : g_bad_w
      $error("uart_evt_irq_ctrl: status width too small for the bit map");
   end

   logic             run;
   logic             frz;
   logic             live;
   logic             bit_err;
   logic             edge_pulse;
   logic             edge_pending;
   logic [SRC_N-1:0] set_v;
   logic [SRC_N-1:0] clr_v;
   logic [SRC_N-1:0] mask_v;
   logic [SRC_N-1:0] flags;
   logic             unused_clr_bits;

   assign run     = ~stop_i;
   assign frz     = wait_i & wait_halt_en_i;
   assign live    = ~frz;
   assign halt_o  = frz;
   assign bit_err = one_wire_i & bit_chk_i & (tx_bit_i ^ line_bit_i);

   always_comb begin
      set_v         = '0;
      set_v[IX_TXE] = live & tx_empty_evt_i;
      set_v[IX_TXC] = live & tx_done_evt_i;
      set_v[IX_RXF] = live & rx_full_evt_i;
      set_v[IX_IDL] = live & rx_idle_evt_i;
      set_v[IX_OVR] = live & rx_overrun_evt_i;
      set_v[IX_EDG] = edge_pulse;
      set_v[IX_BER] = live & bit_err;
      set_v[IX_BRK] = live & rx_break_evt_i;
   end

   always_comb begin
      clr_v         = '0;
      clr_v[IX_TXE] = clr_main_i[MB_TXE];
      clr_v[IX_TXC] = clr_main_i[MB_TXC];
      clr_v[IX_RXF] = clr_main_i[MB_RXF];
      clr_v[IX_IDL] = clr_main_i[MB_IDL];
      clr_v[IX_OVR] = clr_main_i[MB_OVR];
      clr_v[IX_EDG] = clr_aux_i[AB_EDG];
      clr_v[IX_BER] = clr_aux_i[AB_BER];
      clr_v[IX_BRK] = clr_aux_i[AB_BRK];
   end

   assign unused_clr_bits = ^{clr_main_i[2:0], clr_aux_i[6:2]};

   always_comb begin
      mask_v         = '0;
      mask_v[IX_TXE] = irq_en_i[EN_TXE];
      mask_v[IX_TXC] = irq_en_i[EN_TXC];
      mask_v[IX_RXF] = irq_en_i[EN_RX];
      mask_v[IX_OVR] = irq_en_i[EN_RX];
      mask_v[IX_IDL] = irq_en_i[EN_IDL];
      mask_v[IX_EDG] = irq_en_i[EN_EDG];
      mask_v[IX_BER] = irq_en_i[EN_BER];
      mask_v[IX_BRK] = irq_en_i[EN_BRK];
   end

   uart_rx_edge_wake #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .run_i        (run),
      .rx_pin_i     (rx_pin_i),
      .pol_i        (edge_pol_i),
      .edge_pulse_o (edge_pulse),
      .pending_o    (edge_pending)
   );

   uart_flag_bank #(.N(SRC_N)) u_flags (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run),
      .set_i  (set_v),
      .clr_i  (clr_v),
      .flag_o (flags)
   );

   uart_irq_merge #(.N(SRC_N)) u_merge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run),
      .flag_i (flags),
      .mask_i (mask_v),
      .irq_o  (irq_o)
   );

   always_comb begin
      stat_main_o         = '0;
      stat_main_o[MB_TXE] = flags[IX_TXE];
      stat_main_o[MB_TXC] = flags[IX_TXC];
      stat_main_o[MB_RXF] = flags[IX_RXF];
      stat_main_o[MB_IDL] = flags[IX_IDL];
      stat_main_o[MB_OVR] = flags[IX_OVR];
      stat_aux_o          = '0;
      stat_aux_o[AB_EDG]  = flags[IX_EDG];
      stat_aux_o[AB_BER]  = flags[IX_BER];
      stat_aux_o[AB_BRK]  = flags[IX_BRK];
   end

   assign wake_o = edge_pending & stop_i;

   a_r7_edge_only_from_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flags[IX_EDG] && !edge_pulse) |=> !flags[IX_EDG]);
   a_r9_frozen_rx_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (halt_o && !flags[IX_RXF]) |=> !flags[IX_RXF]);
   a_r8_no_err_two_wire: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!one_wire_i && !flags[IX_BER]) |=> !flags[IX_BER]);
   a_r10_irq_held_in_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_i |=> $stable(irq_o));
endmodule

// File: tb/uart_evt_irq_ctrl_test.sv
`timescale 1ns/1ps
module uart_evt_irq_ctrl_test;
   logic clk = 1'b0;
   logic rst_ni = 1'b0;
   logic txe = 0, txc = 0, rxf = 0, idl = 0, ovr = 0, brk = 0;
   logic one_wire = 0, chk = 0, tx_bit = 0, line_bit = 0;
   logic rx_pin = 1'b1, pol = 1'b0;
   logic [6:0] en = '0;
   logic [7:0] clr_m = '0, clr_a = '0;
   logic wait_m = 0, halt_en = 0, stop_m = 0;
   logic [7:0] st_m, st_a;
   logic irq, wake, halt;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   always #4 clk = ~clk;

   uart_evt_irq_ctrl uut (
      .clk_i(clk), .rst_ni(rst_ni),
      .tx_empty_evt_i(txe), .tx_done_evt_i(txc), .rx_full_evt_i(rxf),
      .rx_idle_evt_i(idl), .rx_overrun_evt_i(ovr), .rx_break_evt_i(brk),
      .one_wire_i(one_wire), .bit_chk_i(chk), .tx_bit_i(tx_bit), .line_bit_i(line_bit),
      .rx_pin_i(rx_pin), .edge_pol_i(pol), .irq_en_i(en),
      .clr_main_i(clr_m), .clr_aux_i(clr_a),
      .wait_i(wait_m), .wait_halt_en_i(halt_en), .stop_i(stop_m),
      .stat_main_o(st_m), .stat_aux_o(st_a), .irq_o(irq), .wake_o(wake), .halt_o(halt)
   );

   // {evt[39:32], 0, en[30:24], main[23:16], aux[15:8], 7'b0, irq}
   // evt bits: 0 txe, 1 txc, 2 rxf, 3 idle, 4 overrun, 5 break, 6 bit error
   localparam int NV = 9;
   localparam logic [39:0] VEC [NV] = '{
      40'h01_00_80_00_00,
      40'h02_02_40_00_01,
      40'h04_04_20_00_01,
      40'h10_04_08_00_01,
      40'h08_77_10_00_00,
      40'h20_40_00_01_01,
      40'h40_20_00_02_01,
      40'h05_01_A0_00_01,
      40'h02_10_40_00_00
   };

   task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input logic [7:0] e);
      txe = e[0]; txc = e[1]; rxf = e[2]; idl = e[3]; ovr = e[4]; brk = e[5];
      one_wire = e[6]; chk = e[6]; tx_bit = e[6]; line_bit = 1'b0;
      cyc(1);
      txe = 0; txc = 0; rxf = 0; idl = 0; ovr = 0; brk = 0;
      one_wire = 0; chk = 0; tx_bit = 0;
   endtask

   task automatic clear_all();
      clr_m = 8'hFF; clr_a = 8'hFF;
      cyc(1);
      clr_m = 8'h00; clr_a = 8'h00;
      cyc(2);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      cyc(3);
      // R1 reset state
      chk_eq("R1 main after reset", st_m, 8'h00);
      chk_eq("R1 aux after reset", st_a, 8'h00);
      chk_eq("R1 irq/wake/halt after reset", {irq, wake, halt}, 3'b000);
      rst_ni = 1'b1;
      cyc(2);
      chk_eq("R1 main after release", st_m, 8'h00);

      // R2 R5 R6 vector walk
      for (int i = 0; i < NV; i++) begin
         logic [39:0] v;
         v = VEC[i];
         clear_all();
         en = v[30:24];
         pulse(v[39:32]);
         chk_eq($sformatf("R2 main vec %0d", i), st_m, v[23:16]);
         chk_eq($sformatf("R2 aux vec %0d", i), st_a, v[15:8]);
         chk_eq($sformatf("R5 irq not yet vec %0d", i), irq, 1'b0);
         cyc(1);
         chk_eq($sformatf("R5 R6 irq vec %0d", i), irq, v[0]);
      end

      // R3 write-one-to-clear; state: main=A0, en=01, irq=1
      clear_all();
      en = 7'h01;
      pulse(8'h05);
      cyc(1);
      clr_m = 8'h00; cyc(1);
      chk_eq("R3 zero write no effect", st_m, 8'hA0);
      clr_m = 8'h07; cyc(1); clr_m = 8'h00;
      chk_eq("R3 unused bits write no effect", st_m, 8'hA0);
      clr_m = 8'h80; cyc(1); clr_m = 8'h00;
      chk_eq("R3 clear one bit", st_m, 8'h20);
      chk_eq("R5 irq still high one cycle", irq, 1'b1);
      cyc(1);
      chk_eq("R5 irq falls after last clear", irq, 1'b0);

      // R4 set beats clear
      clear_all();
      clr_m = 8'h20;
      pulse(8'h04);
      clr_m = 8'h00;
      chk_eq("R4 set wins over clear", st_m, 8'h20);

      // R8 bit error qualification
      clear_all();
      one_wire = 1; chk = 1; tx_bit = 1; line_bit = 1; cyc(1);
      chk_eq("R8 match no error", st_a, 8'h00);
      one_wire = 0; line_bit = 0; cyc(1);
      chk_eq("R8 two-wire no error", st_a, 8'h00);
      one_wire = 1; chk = 0; cyc(1);
      chk_eq("R8 no strobe no error", st_a, 8'h00);
      chk = 1; cyc(1);
      one_wire = 0; chk = 0; tx_bit = 0;
      chk_eq("R8 mismatch sets error", st_a, 8'h02);

      // R9 wait freeze
      clear_all();
      wait_m = 1; halt_en = 1; cyc(1);
      chk_eq("R9 halt out", halt, 1'b1);
      pulse(8'h0C);
      cyc(1);
      chk_eq("R9 events ignored", st_m, 8'h00);
      halt_en = 0; cyc(1);
      chk_eq("R9 halt low without enable", halt, 1'b0);
      pulse(8'h04);
      chk_eq("R9 wait without freeze", st_m, 8'h20);
      wait_m = 0;

      // R7 edge detection
      clear_all();
      en = 7'h10;
      pol = 0;
      rx_pin = 1'b0; cyc(5);
      chk_eq("R7 falling edge pol0", st_a, 8'h80);
      chk_eq("R7 R5 edge irq", irq, 1'b1);
      clear_all();
      rx_pin = 1'b1; cyc(5);
      chk_eq("R7 rising ignored pol0", st_a, 8'h00);
      rx_pin = 1'b0; cyc(5);
      clear_all();
      pol = 1; cyc(5);
      chk_eq("R7 polarity switch at low", st_a, 8'h00);
      rx_pin = 1'b1; cyc(5);
      chk_eq("R7 rising edge pol1", st_a, 8'h80);
      clear_all();
      rx_pin = 1'b0; cyc(5);
      chk_eq("R7 falling ignored pol1", st_a, 8'h00);

      // R10 stop mode
      clear_all();
      en = 7'h01;
      pulse(8'h01);
      cyc(1);
      stop_m = 1; cyc(1);
      clr_m = 8'h80; cyc(1); clr_m = 8'h00;
      pulse(8'h04);
      chk_eq("R10 flags held in stop", st_m, 8'h80);
      chk_eq("R10 irq held in stop", irq, 1'b1);
      chk_eq("R10 no wake before edge", wake, 1'b0);
      #1 rx_pin = 1'b1;
      #1;
      chk_eq("R10 wake on edge in stop", wake, 1'b1);
      cyc(3);
      chk_eq("R10 edge flag waits for clock", st_a, 8'h00);
      stop_m = 0;
      cyc(6);
      chk_eq("R10 edge flag after stop", st_a, 8'h80);
      chk_eq("R10 wake cleared", wake, 1'b0);

      // R11 reset during stop
      rx_pin = 1'b0; cyc(5);
      stop_m = 1; cyc(1);
      rx_pin = 1'b1; #2;
      chk_eq("R11 wake pending before reset", wake, 1'b1);
      rst_ni = 1'b0; cyc(1);
      chk_eq("R11 reset clears flags", {st_m, st_a}, 16'h0000);
      chk_eq("R11 reset clears irq and wake", {irq, wake}, 2'b00);
      rst_ni = 1'b1; stop_m = 0; cyc(2);

      done = 1;
      finish_run();
   end
endmodule